// File: doc/BRIEF.md
# Low-Power Wake Event Detector

This block runs from the always-on clock and keeps working while the bus clock is stopped. It watches three wake sources: an AC-present line, a power-button line and a lid-open line. A wake event on the AC line is a rise to 1. On the power button it is a fall to 0, because the button is active low. On the lid line it is a rise to 1. Each source has its own 16-bit debounce count. When a source reaches its wake level and stays there for its full count, a sticky wake flag is set. The flag stays set until an explicit clear.

A global enable gates the whole detector. Clearing the enable sends every source back to idle straight away. Detection starts only on a transition into the wake level that is seen while the enable is set. A line that already sits at its wake level starts nothing. All inputs are assumed to be already synchronised to the always-on clock. The count inputs are assumed to be held steady while a debounce is running.

Top module: `wake_detect_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), wake_o is 0 and every source is idle.
- R2: The AC line (ac_i) wakes on a 0-to-1 transition. If the line is at 1 on ac_cnt_i+2 consecutive clock edges, starting at the edge that first sees the 1, wake_o is 1 after the last of those edges.
- R3: The power button line (pwrb_i) wakes on a 1-to-0 transition. If the line is at 0 on pwrb_cnt_i+2 consecutive edges, wake_o is set after the last of those edges.
- R4: The lid line (lid_i) wakes on a 0-to-1 transition. If the line is at 1 on lid_cnt_i+2 consecutive edges, wake_o is set after the last of those edges.
- R5: If a source is back at its idle level by the edge that would complete its count (its wake level is seen on only count+1 edges), that source does not set wake_o.
- R6: If en_i is 0 at any edge during a debounce, that source returns to idle and sets nothing. Setting en_i again while the line is still at its wake level does not resume the debounce.
- R7: A line that is already at its wake level when en_i rises starts no debounce. With en_i at 0, transitions are ignored.
- R8: wake_o is sticky. It stays 1 after the source returns to idle. clr_i clears it at the next edge, except when a debounce completes at that same edge; in that case the set wins.
- R9: Each source uses only its own count. Sources debounce at the same time without affecting each other.
- R10: A count of 0 sets wake_o after two consecutive edges at the wake level. The count is 16 bits wide, so values above 255 take effect in full.
- R11: After a source completes its debounce, it must leave its wake level and come back before it can set wake_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Global detector enable |
| clr_i | input | 1 | Clears the sticky wake flag |
| ac_i | input | 1 | AC-present line (wakes when it rises) |
| pwrb_i | input | 1 | Power button line, active low (wakes when it falls) |
| lid_i | input | 1 | Lid-open line (wakes when it rises) |
| ac_cnt_i | input | 16 | Debounce count for the AC line |
| pwrb_cnt_i | input | 16 | Debounce count for the power button |
| lid_cnt_i | input | 16 | Debounce count for the lid line |
| wake_o | output | 1 | Sticky wake flag |

## Verification
The assertions check these behaviours on every cycle:
- a source that leaves its wake level, or loses the enable, is idle on the next edge;
- an idle source whose line is already at its wake level stays idle;
- the counter is zero whenever the source is idle;
- the flag holds its value unless a completion or a clear arrives, and a clear with no completion empties it.

Only the bench's scenarios can show the exact count+2 edge threshold and the off-by-one neighbour count+1. The same holds for the set-over-clear priority, the independence of simultaneous sources, and the need for a fresh transition after a completion. Those come from a behavioural model compared against wake_o on every clock.

// File: rtl/wake_pkg.sv
// Package: shared constants and the per-source state type for the wake detector.
// Assumes: three sources, indexed 0 = AC, 1 = power button, 2 = lid.
package wake_pkg;
    localparam int NUM_SRC = 3;
    localparam int CNT_W   = 16;
    // Wake level of each source, one bit per index (AC high, button low, lid high).
    localparam logic [NUM_SRC-1:0] WAKE_LVL = 3'b101;

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_DEB  = 1'b1
    } src_state_e;
endpackage

// File: rtl/wake_debounce.sv
// Module: one debounced wake source. A debounce starts on a transition into
// WAKE_LVL seen while enabled. It counts while the line holds that level, and
// it pulses hit_o at the edge where the count reaches limit_i.
// Assumes: line_i is already synchronous to clk, and limit_i is steady during a debounce.
module wake_debounce
    import wake_pkg::*;
#(
    parameter int   W   = 16,
    parameter logic LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         line_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic       at_lvl;
    logic       at_prev_q;
    src_state_e st_q;
    logic [W-1:0] cnt_q;

    // Decode whether the line sits at its wake level this cycle.
    assign at_lvl = (line_i == LVL);

    // Completion: still debouncing, still enabled, still at level, count reached.
    assign hit_o = (st_q == SRC_DEB) && en_i && at_lvl && (cnt_q >= limit_i);

    // Track the previous level. It resets to "at level" so that a line stuck
    // active out of reset needs a fresh transition.
    always_ff @(posedge clk) begin
        if (!rst_n) at_prev_q <= 1'b1;
        else        at_prev_q <= at_lvl;
    end

    // State and counter: enter on a qualified transition, leave on loss, disable or hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SRC_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SRC_IDLE: begin
                    cnt_q <= '0;
                    if (en_i && at_lvl && !at_prev_q) st_q <= SRC_DEB;
                end
                default: begin
                    if (!en_i || !at_lvl || hit_o) begin
                        st_q  <= SRC_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R5
    // no_hold_loss_chk
    no_hold_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SRC_DEB && !at_lvl) |=> (st_q == SRC_IDLE));

    // R6
    // no_disable_hold_chk
    no_disable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (st_q == SRC_IDLE));

    // R7
    // no_level_start_chk
    no_level_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SRC_IDLE && at_prev_q) |=> (st_q == SRC_IDLE));

    // R10
    // idle_cnt_zero_chk
    idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SRC_IDLE) |-> (cnt_q == '0));
endmodule

// File: rtl/wake_status.sv
// Module: sticky wake flag. A completion from any source sets it and clr_i
// empties it; when both arrive at the same edge, the set wins.
// Assumes: set_i pulses are one cycle wide and synchronous to clk.
module wake_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic         wake_o
);
    logic any_set;

    // Merge the completion pulses of all sources.
    assign any_set = |set_i;

    // Update the flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       wake_o <= 1'b0;
        else if (any_set) wake_o <= 1'b1;
        else if (clr_i)   wake_o <= 1'b0;
    end

    // R8
    // flag_sticky_chk
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !any_set && !clr_i) |=> wake_o);

    // R8
    // flag_clear_chk
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !any_set) |=> !wake_o);

    // R8
    // flag_set_chk
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_set |=> wake_o);
endmodule

// File: rtl/wake_detect_top.sv
// Module: low-power wake detector top. It packs the three source lines and
// counts into arrays, runs one debouncer per source and merges their completions.
// Assumes: all inputs are synchronous to the always-on clock.
module wake_detect_top
    import wake_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             ac_i,
    input  logic             pwrb_i,
    input  logic             lid_i,
    input  logic [CNT_W-1:0] ac_cnt_i,
    input  logic [CNT_W-1:0] pwrb_cnt_i,
    input  logic [CNT_W-1:0] lid_cnt_i,
    output logic             wake_o
);
    logic [NUM_SRC-1:0] lines;
    logic [CNT_W-1:0]   limits [NUM_SRC];
    logic [NUM_SRC-1:0] hits;

    // Gather the per-source lines and counts into indexed form.
    always_comb begin
        lines     = {lid_i, pwrb_i, ac_i};
        limits[0] = ac_cnt_i;
        limits[1] = pwrb_cnt_i;
        limits[2] = lid_cnt_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        wake_debounce #(
            .W   (CNT_W),
            .LVL (WAKE_LVL[g])
        ) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .line_i  (lines[g]),
            .limit_i (limits[g]),
            .hit_o   (hits[g])
        );
    end

    wake_status #(
        .N (NUM_SRC)
    ) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hits),
        .clr_i  (clr_i),
        .wake_o (wake_o)
    );
endmodule

// File: tb/tb_wake_detect_top.sv
// Bench: a behavioural model, updated at each rising edge, is compared with
// wake_o at every falling edge. Directed scenarios add named checks.
module tb_wake_detect_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        ac_i = 1'b0;
    logic        pwrb_i = 1'b1;
    logic        lid_i = 1'b0;
    logic [15:0] ac_cnt_i = 16'd5;
    logic [15:0] pwrb_cnt_i = 16'd8;
    logic [15:0] lid_cnt_i = 16'd12;
    logic        wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    int  m_deb [3];
    int  m_cnt [3];
    bit  m_prev [3];
    bit  m_wake = 1'b0;
    bit  m_live = 1'b0;

    always #2 clk = ~clk;

    wake_detect_top dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(clr_i),
        .ac_i(ac_i), .pwrb_i(pwrb_i), .lid_i(lid_i),
        .ac_cnt_i(ac_cnt_i), .pwrb_cnt_i(pwrb_cnt_i), .lid_cnt_i(lid_cnt_i),
        .wake_o(wake_o)
    );

    function automatic bit active(int i);
        case (i)
            0: return ac_i == 1'b1;
            1: return pwrb_i == 1'b0;
            default: return lid_i == 1'b1;
        endcase
    endfunction

    function automatic int limit(int i);
        case (i)
            0: return int'(ac_cnt_i);
            1: return int'(pwrb_cnt_i);
            default: return int'(lid_cnt_i);
        endcase
    endfunction

    // Reference model evaluated at every rising edge.
    always @(posedge clk) begin
        bit any_hit;
        any_hit = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_deb[i] = 0; m_cnt[i] = 0; m_prev[i] = 1'b1;
            end
            m_wake = 1'b0;
            m_live = 1'b1;
        end else begin
            for (int i = 0; i < 3; i++) begin
                bit a;
                a = active(i);
                if (m_deb[i] == 0) begin
                    if (en_i && a && !m_prev[i]) begin
                        m_deb[i] = 1; m_cnt[i] = 0;
                    end
                end else if (!en_i || !a) begin
                    m_deb[i] = 0; m_cnt[i] = 0;
                end else if (m_cnt[i] >= limit(i)) begin
                    any_hit = 1'b1; m_deb[i] = 0; m_cnt[i] = 0;
                end else begin
                    m_cnt[i] = m_cnt[i] + 1;
                end
                m_prev[i] = a;
            end
            if (any_hit) m_wake = 1'b1;
            else if (clr_i) m_wake = 1'b0;
        end
    end

    // Every-cycle comparison against the model (R8 flag semantics).
    always @(negedge clk) begin
        if (m_live && !done) begin
            checks++;
            if (wake_o !== m_wake) begin
                errors++;
                $display("FAIL R8 model compare at %0t: actual=%0b expected=%0b",
                         $time, wake_o, m_wake);
            end
        end
    end

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_src(int i, bit act);
        case (i)
            0: ac_i = act;
            1: pwrb_i = !act;
            default: lid_i = act;
        endcase
    endtask

    // Hold a source at its wake level for n edges, then return it to idle.
    task automatic pulse(int i, int n);
        set_src(i, 1'b1);
        wait_n(n);
        set_src(i, 1'b0);
    endtask

    task automatic clear();
        clr_i = 1'b1;
        wait_n(1);
        clr_i = 1'b0;
        wait_n(1);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        // R1: reset state
        check("R1 reset", wake_o, 1'b0);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 after release", wake_o, 1'b0);
        en_i = 1'b1;
        wait_n(2);

        // R5: AC held count+1 edges
        pulse(0, 6); wait_n(3);
        check("R5 ac short", wake_o, 1'b0);
        // R2: AC held count+2 edges
        pulse(0, 7); wait_n(3);
        check("R2 ac wake", wake_o, 1'b1);
        clear();
        check("R8 clear", wake_o, 1'b0);

        // R3: power button
        pulse(1, 9); wait_n(3);
        check("R5 pwrb short", wake_o, 1'b0);
        pulse(1, 10); wait_n(3);
        check("R3 pwrb wake", wake_o, 1'b1);
        wait_n(5);
        check("R8 sticky", wake_o, 1'b1);
        clear();

        // R4: lid
        pulse(2, 13); wait_n(3);
        check("R5 lid short", wake_o, 1'b0);
        pulse(2, 14); wait_n(3);
        check("R4 lid wake", wake_o, 1'b1);
        clear();

        // R6 and R7: disable mid-debounce, then re-enable with line still active
        set_src(2, 1'b1);
        wait_n(6);
        en_i = 1'b0;
        wait_n(20);
        check("R6 disabled", wake_o, 1'b0);
        en_i = 1'b1;
        wait_n(20);
        check("R7 level at enable", wake_o, 1'b0);
        set_src(2, 1'b0);
        // R7: transitions ignored while disabled
        en_i = 1'b0;
        wait_n(2);
        pulse(0, 12); wait_n(3);
        check("R7 disabled edge", wake_o, 1'b0);
        en_i = 1'b1;
        wait_n(2);

        // R8: set wins over a simultaneous clear
        clr_i = 1'b1;
        set_src(0, 1'b1);
        wait_n(7);
        check("R8 set wins", wake_o, 1'b1);
        wait_n(1);
        check("R8 later clear", wake_o, 1'b0);
        clr_i = 1'b0;
        // R11: held line after completion, clear, no rearm
        wait_n(3);
        clear();
        wait_n(20);
        check("R11 no rearm", wake_o, 1'b0);
        set_src(0, 1'b0);
        wait_n(3);

        // R9: simultaneous sources with independent counts
        set_src(0, 1'b1); set_src(2, 1'b1);
        wait_n(6);
        set_src(0, 1'b0);
        wait_n(7);
        set_src(2, 1'b0);
        wait_n(3);
        check("R9 both short", wake_o, 1'b0);
        set_src(0, 1'b1); set_src(2, 1'b1);
        wait_n(7);
        set_src(0, 1'b0);
        wait_n(2);
        check("R9 ac first", wake_o, 1'b1);
        wait_n(4);
        set_src(2, 1'b0);
        wait_n(2);
        clear();

        // R10: zero count and a wide count
        ac_cnt_i = 16'd0;
        wait_n(2);
        pulse(0, 1); wait_n(3);
        check("R10 zero short", wake_o, 1'b0);
        pulse(0, 2); wait_n(3);
        check("R10 zero wake", wake_o, 1'b1);
        clear();
        pwrb_cnt_i = 16'd300;
        wait_n(2);
        pulse(1, 301); wait_n(3);
        check("R10 wide short", wake_o, 1'b0);
        pulse(1, 302); wait_n(3);
        check("R10 wide wake", wake_o, 1'b1);
        clear();

        // R1: reset clears the flag
        pulse(0, 2); wait_n(2);
        rst_n = 1'b0;
        wait_n(2);
        check("R1 reset clears", wake_o, 1'b0);
        rst_n = 1'b1;
        wait_n(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule